// File: doc/BRIEF.md
# Active Priority Bitmap Tracker

This block keeps track of which interrupt priority levels are currently active on one virtual processor. It holds two banks of 32-bit bitmaps, one for group 0 and one for group 1, with up to four registers in each bank. A set bit marks an active preemption level. The block also holds the two binary point values and a flag that makes group 1 share the group 0 binary point.

Priorities are first masked by the binary point of their group. They are then stored at a resolution set by the smallest legal binary point, so a stored bit does not move when software changes a binary point later. The running priority is found by merging both banks and taking the lowest set bit. A drop operation clears that bit and returns the level that was dropped.

A static 3-bit configuration input sets the number of implemented preemption bits, from 5 to 7. That number fixes how many bitmap registers are live and what the minimum binary point is. Operations arrive one per cycle on a command port. Each one is answered by a registered response in the following cycle.

Top module: `apt_tracker`

## Requirements
- R1: After reset all bitmap registers are zero, `run_prio` is 0xFF, `rsp_valid` is 0, the common flag is clear, and the group 0 and group 1 binary points read 2 and 3.
- R2: The preemption bit count is `cfg_prebits_m1`+1, clamped to the range 5..7. The number of live registers per bank is 2^(count−5), and the minimum binary point is 8 − count.
- R3: `op_code`=1 (set active) computes level = (`op_prio` & (0xFF << effective binary point)) >> minimum binary point. It sets bit level%32 of register level/32 in the bank selected by `op_grp` (0 = group 0, 1 = group 1).
- R4: The effective binary point is BP0+1 for group 0 and BP1 for group 1. While the common flag is set, group 1 uses BP0+1 instead, saturating at 7.
- R5: `run_prio` scans the live registers from index 0 upward with both banks ORed together. It shows (32·index + lowest set bit) << minimum binary point for the first nonzero register, or 0xFF when every bit is clear.
- R6: `op_code`=2 (drop) looks at the first register where either bank is nonzero and takes the lowest set bit of each bank, counting an empty bank as 32. It clears the group 0 bit only when its position is strictly lower; otherwise, including a tie, it clears the group 1 bit. It returns the rescaled level of the cleared bit, or 0xFF when nothing was set.
- R7: `op_code`=3 reads and `op_code`=4 writes the whole register `op_idx` of bank `op_grp`. An index at or beyond the live count reads 0 and a write to it changes nothing.
- R8: `op_code`=6 writes `op_wdata[2:0]` to the binary point of `op_grp`. For group 0 a value below the minimum binary point minus one is raised to that bound. For group 1 a value below the minimum binary point is raised to the minimum.
- R9: `op_code`=7 loads the common flag from `op_wdata[0]`. While the flag is set, a group 1 binary point write is dropped and a group 1 read (`op_code`=5) returns BP0+1 saturated at 7. Clearing the flag brings back the stored group 1 value.
- R10: `rsp_valid` is high in exactly the cycle after an accepted op. `rsp_data` holds the read value for reads (zero-extended), the dropped level for drop, and 0 for every other op.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_prebits_m1 | input | 3 | Implemented preemption bits minus one (static) |
| op_valid | input | 1 | Operation present this cycle |
| op_code | input | 3 | 0 none, 1 set active, 2 drop, 3 bitmap read, 4 bitmap write, 5 binary point read, 6 binary point write, 7 common flag write |
| op_grp | input | 1 | Group selector |
| op_idx | input | 2 | Bitmap register index |
| op_prio | input | 8 | Priority for set active |
| op_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response present |
| rsp_data | output | 32 | Response value |
| run_prio | output | 8 | Current running priority |

## Verification
The bench forces a drop tie, where both banks hold the same lowest bit. A design that favours group 0 there would leave the group 1 bit set, and the following bitmap read would show it. It writes binary point values below each group's floor and checks that each group gets its own bound; an off-by-one floor reads back one too high or too low. It writes group 1 while the common flag is set, then clears the flag and checks that the earlier value comes back. It also sets a group 0 level with BP0 at 7, so the mask removes every bit and the level must land at index 0. Finally it checks register indices beyond the live count under the smaller configurations: a design that ignored the live count would read back written data there, or would report a running priority from a register that should not exist.

// File: rtl/apt_pkg.sv
package apt_pkg;

    localparam int REG_W  = 32;
    localparam int PRIO_W = 8;
    localparam logic [PRIO_W-1:0] IDLE_PRIO = 8'hFF;

    typedef enum logic [2:0] {
        OP_NOP    = 3'd0,
        OP_SET    = 3'd1,
        OP_DROP   = 3'd2,
        OP_APR_RD = 3'd3,
        OP_APR_WR = 3'd4,
        OP_BP_RD  = 3'd5,
        OP_BP_WR  = 3'd6,
        OP_CBP_WR = 3'd7
    } apt_op_e;

    // position of lowest set bit, 32 when the word is empty
    function automatic logic [5:0] low_bit(input logic [REG_W-1:0] v);
        logic [5:0] pos;
        pos = 6'd32;
        for (int i = REG_W - 1; i >= 0; i--) begin
            if (v[i]) pos = 6'(i);
        end
        return pos;
    endfunction

endpackage

// File: rtl/apt_bank.sv
module apt_bank
    import apt_pkg::*;
#(
    parameter int NUM_REGS = 4,
    parameter int IDX_W    = 2,
    parameter int BIT_W    = 7,
    parameter int CNT_W    = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [CNT_W-1:0]          nregs,
    input  logic                      wr_en,
    input  logic [IDX_W-1:0]          wr_idx,
    input  logic [REG_W-1:0]          wr_data,
    input  logic                      set_en,
    input  logic [BIT_W-1:0]          set_bit,
    input  logic                      clr_en,
    input  logic [BIT_W-1:0]          clr_bit,
    output logic [NUM_REGS*REG_W-1:0] regs_q
);

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        localparam logic [IDX_W-1:0] GI = IDX_W'(g);
        logic [REG_W-1:0] word_q;
        logic             live;

        assign live = CNT_W'(g) < nregs;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                word_q <= '0;
            end else if (live) begin
                if (wr_en && wr_idx == GI) begin
                    word_q <= wr_data;
                end else begin
                    if (set_en && set_bit[BIT_W-1:5] == GI) word_q[set_bit[4:0]] <= 1'b1;
                    if (clr_en && clr_bit[BIT_W-1:5] == GI) word_q[clr_bit[4:0]] <= 1'b0;
                end
            end
        end

        assign regs_q[g*REG_W +: REG_W] = word_q;
    end

endmodule

// File: rtl/apt_scan.sv
module apt_scan
    import apt_pkg::*;
#(
    parameter int NUM_REGS = 4,
    parameter int IDX_W    = 2,
    parameter int BIT_W    = 7,
    parameter int CNT_W    = 3
) (
    input  logic [NUM_REGS*REG_W-1:0] bank0,
    input  logic [NUM_REGS*REG_W-1:0] bank1,
    input  logic [CNT_W-1:0]          nregs,
    output logic                      found,
    output logic                      grp0_wins,
    output logic [BIT_W-1:0]          hap,
    output logic [BIT_W-1:0]          hit_bit0,
    output logic [BIT_W-1:0]          hit_bit1
);

    logic [IDX_W-1:0] hit;
    logic [5:0]       c0, c1, cmin;

    always_comb begin
        found = 1'b0;
        hit   = '0;
        for (int i = NUM_REGS - 1; i >= 0; i--) begin
            if (CNT_W'(i) < nregs &&
                (bank0[i*REG_W +: REG_W] | bank1[i*REG_W +: REG_W]) != '0) begin
                found = 1'b1;
                hit   = IDX_W'(i);
            end
        end
        c0        = low_bit(bank0[hit*REG_W +: REG_W]);
        c1        = low_bit(bank1[hit*REG_W +: REG_W]);
        grp0_wins = c0 < c1;
        cmin      = grp0_wins ? c0 : c1;
        hap       = {hit, cmin[4:0]};
        hit_bit0  = {hit, c0[4:0]};
        hit_bit1  = {hit, c1[4:0]};
    end

endmodule

// File: rtl/apt_binpoint.sv
module apt_binpoint #(
    parameter logic [2:0] RST_BP0 = 3'd2,
    parameter logic [2:0] RST_BP1 = 3'd3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [3:0] bpr_min,
    input  logic       wr_en,
    input  logic       wr_grp,
    input  logic [2:0] wr_val,
    input  logic       cbp_wr,
    input  logic       cbp_val,
    output logic [3:0] eff_bp0,
    output logic [3:0] eff_bp1,
    output logic [2:0] rd_bp0,
    output logic [2:0] rd_bp1
);

    logic [2:0] bp0_q, bp1_q, floor0, floor1, bp0_sat;
    logic       cbp_q;

    assign floor0  = 3'(bpr_min - 4'd1);
    assign floor1  = 3'(bpr_min);
    assign bp0_sat = (bp0_q == 3'd7) ? 3'd7 : bp0_q + 3'd1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bp0_q <= RST_BP0;
            bp1_q <= RST_BP1;
            cbp_q <= 1'b0;
        end else begin
            if (cbp_wr) cbp_q <= cbp_val;
            if (wr_en && !wr_grp) bp0_q <= (wr_val < floor0) ? floor0 : wr_val;
            if (wr_en && wr_grp && !cbp_q) bp1_q <= (wr_val < floor1) ? floor1 : wr_val;
        end
    end

    assign eff_bp0 = {1'b0, bp0_q} + 4'd1;
    assign eff_bp1 = cbp_q ? {1'b0, bp0_sat} : {1'b0, bp1_q};
    assign rd_bp0  = bp0_q;
    assign rd_bp1  = cbp_q ? bp0_sat : bp1_q;

endmodule

// File: rtl/apt_tracker.sv
module apt_tracker
    import apt_pkg::*;
#(
    parameter int NUM_REGS = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [2:0]  cfg_prebits_m1,
    input  logic        op_valid,
    input  logic [2:0]  op_code,
    input  logic        op_grp,
    input  logic [1:0]  op_idx,
    input  logic [7:0]  op_prio,
    input  logic [31:0] op_wdata,
    output logic        rsp_valid,
    output logic [31:0] rsp_data,
    output logic [7:0]  run_prio
);

    localparam int IDX_W = 2;
    localparam int BIT_W = IDX_W + 5;
    localparam int CNT_W = IDX_W + 1;

    apt_op_e          op;
    logic [3:0]       pre_raw, pre_bits, bpr_min;
    logic [CNT_W-1:0] nregs;
    logic [3:0]       eff_bp0, eff_bp1, eff_bp;
    logic [2:0]       rd_bp0, rd_bp1;
    logic [7:0]       preempt, level;
    logic [BIT_W-1:0] set_bit, clr_bit, hap, hit_bit0, hit_bit1;
    logic             found, grp0_wins;
    logic             is_set, is_drop, is_apr_wr;
    logic [NUM_REGS*REG_W-1:0] bank_q [2];
    logic [NUM_REGS*REG_W-1:0] rd_sel;
    logic [31:0]      rsp_next;

    assign op = apt_op_e'(op_code);

    always_comb begin
        pre_raw = {1'b0, cfg_prebits_m1} + 4'd1;
        if (pre_raw < 4'd5)      pre_bits = 4'd5;
        else if (pre_raw > 4'd7) pre_bits = 4'd7;
        else                     pre_bits = pre_raw;
        bpr_min = 4'd8 - pre_bits;
        nregs   = CNT_W'(1) << (pre_bits - 4'd5);
        if (nregs > CNT_W'(NUM_REGS)) nregs = CNT_W'(NUM_REGS);
    end

    assign is_set    = op_valid && op == OP_SET;
    assign is_drop   = op_valid && op == OP_DROP;
    assign is_apr_wr = op_valid && op == OP_APR_WR;

    apt_binpoint u_bp (
        .clk     (clk),
        .rst_n   (rst_n),
        .bpr_min (bpr_min),
        .wr_en   (op_valid && op == OP_BP_WR),
        .wr_grp  (op_grp),
        .wr_val  (op_wdata[2:0]),
        .cbp_wr  (op_valid && op == OP_CBP_WR),
        .cbp_val (op_wdata[0]),
        .eff_bp0 (eff_bp0),
        .eff_bp1 (eff_bp1),
        .rd_bp0  (rd_bp0),
        .rd_bp1  (rd_bp1)
    );

    // normalise the masked priority to the minimum binary point
    assign eff_bp  = op_grp ? eff_bp1 : eff_bp0;
    assign preempt = op_prio & (8'hFF << eff_bp);
    assign level   = preempt >> bpr_min;
    assign set_bit = BIT_W'(level);

    apt_scan #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W), .BIT_W(BIT_W), .CNT_W(CNT_W)) u_scan (
        .bank0     (bank_q[0]),
        .bank1     (bank_q[1]),
        .nregs     (nregs),
        .found     (found),
        .grp0_wins (grp0_wins),
        .hap       (hap),
        .hit_bit0  (hit_bit0),
        .hit_bit1  (hit_bit1)
    );

    assign clr_bit = grp0_wins ? hit_bit0 : hit_bit1;

    for (genvar gi = 0; gi < 2; gi++) begin : g_bank
        logic sel;
        logic clr;
        assign sel = op_grp == 1'(gi);
        assign clr = is_drop && found && (grp0_wins == (gi == 0));

        apt_bank #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W), .BIT_W(BIT_W), .CNT_W(CNT_W)) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .nregs   (nregs),
            .wr_en   (is_apr_wr && sel),
            .wr_idx  (op_idx),
            .wr_data (op_wdata),
            .set_en  (is_set && sel),
            .set_bit (set_bit),
            .clr_en  (clr),
            .clr_bit (clr_bit),
            .regs_q  (bank_q[gi])
        );
    end

    always_comb begin
        run_prio = found ? (8'(hap) << bpr_min) : IDLE_PRIO;
    end

    assign rd_sel = op_grp ? bank_q[1] : bank_q[0];

    always_comb begin
        rsp_next = '0;
        unique case (op)
            OP_DROP:   rsp_next = {24'd0, run_prio};
            OP_APR_RD: rsp_next = (CNT_W'(op_idx) < nregs) ? rd_sel[op_idx*REG_W +: REG_W] : '0;
            OP_BP_RD:  rsp_next = {29'd0, op_grp ? rd_bp1 : rd_bp0};
            OP_NOP, OP_SET, OP_APR_WR, OP_BP_WR, OP_CBP_WR: rsp_next = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= op_valid;
            rsp_data  <= op_valid ? rsp_next : '0;
        end
    end

endmodule

// File: rtl/apt_tracker_chk.sv
module apt_tracker_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [2:0]  cfg_prebits_m1,
    input logic        op_valid,
    input logic [2:0]  op_code,
    input logic [1:0]  op_idx,
    input logic        rsp_valid,
    input logic [31:0] rsp_data,
    input logic [7:0]  run_prio
);

    logic [3:0] pre_c, bmin_c;
    logic [2:0] live_c;
    logic [7:0] low_mask;

    always_comb begin
        pre_c = {1'b0, cfg_prebits_m1} + 4'd1;
        if (pre_c < 4'd5) pre_c = 4'd5;
        if (pre_c > 4'd7) pre_c = 4'd7;
        bmin_c   = 4'd8 - pre_c;
        live_c   = 3'd1 << (pre_c - 4'd5);
        low_mask = (8'd1 << bmin_c) - 8'd1;
    end

    // R10: response follows an op by one cycle
    a_r10_rsp_after_op: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |=> rsp_valid);
    a_r10_no_rsp_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> !rsp_valid);

    // R5: running level is aligned to the minimum binary point
    a_r5_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        (run_prio != 8'hFF) |-> ((run_prio & low_mask) == 8'd0));

    // R6: drop returns the running level seen when it was issued
    a_r6_drop_returns_running: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == 3'd2) |=> (rsp_data == {24'd0, $past(run_prio)}));

    // R3: a set leaves something active
    a_r3_set_makes_active: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == 3'd1) |=> (run_prio != 8'hFF));

    // R7: out-of-range bitmap read returns zero
    a_r7_oob_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == 3'd3 && {1'b0, op_idx} >= live_c) |=> (rsp_data == 32'd0));

endmodule

bind apt_tracker apt_tracker_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .cfg_prebits_m1 (cfg_prebits_m1),
    .op_valid       (op_valid),
    .op_code        (op_code),
    .op_idx         (op_idx),
    .rsp_valid      (rsp_valid),
    .rsp_data       (rsp_data),
    .run_prio       (run_prio)
);

// File: tb/apt_tracker_test.sv
module apt_tracker_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  cfg_prebits_m1 = 3'd6;
    logic        op_valid = 1'b0;
    logic [2:0]  op_code = 3'd0;
    logic        op_grp = 1'b0;
    logic [1:0]  op_idx = 2'd0;
    logic [7:0]  op_prio = 8'd0;
    logic [31:0] op_wdata = 32'd0;
    logic        rsp_valid;
    logic [31:0] rsp_data;
    logic [7:0]  run_prio;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    apt_tracker uut (
        .clk(clk), .rst_n(rst_n), .cfg_prebits_m1(cfg_prebits_m1),
        .op_valid(op_valid), .op_code(op_code), .op_grp(op_grp), .op_idx(op_idx),
        .op_prio(op_prio), .op_wdata(op_wdata),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .run_prio(run_prio)
    );

    typedef struct packed {
        logic [3:0]  req;
        logic [2:0]  code;
        logic        grp;
        logic [1:0]  idx;
        logic [7:0]  prio;
        logic [31:0] wdata;
        logic [31:0] rsp;
        logic [7:0]  run;
    } vec_t;

    // seven preemption bits: min binary point 1, four live registers
    localparam int NV = 33;
    localparam vec_t VEC [NV] = '{
        '{4'd3, 3'd1, 1'b1, 2'd0, 8'h40, 32'h0, 32'h0,        8'h40}, // R3 g1 -> reg1 bit0
        '{4'd4, 3'd1, 1'b0, 2'd0, 8'h47, 32'h0, 32'h0,        8'h40}, // R4 g0 bp 3
        '{4'd5, 3'd1, 1'b0, 2'd0, 8'h13, 32'h0, 32'h0,        8'h10}, // R5 reg0 bit8 wins
        '{4'd7, 3'd3, 1'b0, 2'd0, 8'h00, 32'h0, 32'h100,      8'h10}, // R7
        '{4'd7, 3'd3, 1'b1, 2'd1, 8'h00, 32'h0, 32'h1,        8'h10}, // R7
        '{4'd6, 3'd2, 1'b0, 2'd0, 8'h00, 32'h0, 32'h10,       8'h40}, // R6 drop g0 bit8
        '{4'd6, 3'd2, 1'b0, 2'd0, 8'h00, 32'h0, 32'h40,       8'h40}, // R6 tie -> g1
        '{4'd6, 3'd3, 1'b0, 2'd1, 8'h00, 32'h0, 32'h1,        8'h40}, // R6 g0 kept
        '{4'd6, 3'd3, 1'b1, 2'd1, 8'h00, 32'h0, 32'h0,        8'h40}, // R6 g1 cleared
        '{4'd6, 3'd2, 1'b0, 2'd0, 8'h00, 32'h0, 32'h40,       8'hFF}, // R6
        '{4'd6, 3'd2, 1'b0, 2'd0, 8'h00, 32'h0, 32'hFF,       8'hFF}, // R6 empty drop
        '{4'd5, 3'd4, 1'b1, 2'd3, 8'h00, 32'h80000000, 32'h0, 8'hFE}, // R5 top level
        '{4'd5, 3'd4, 1'b0, 2'd2, 8'h00, 32'h30, 32'h0,       8'h88}, // R5
        '{4'd7, 3'd3, 1'b0, 2'd2, 8'h00, 32'h0, 32'h30,       8'h88}, // R7
        '{4'd6, 3'd2, 1'b0, 2'd0, 8'h00, 32'h0, 32'h88,       8'h8A}, // R6
        '{4'd8, 3'd6, 1'b0, 2'd0, 8'h00, 32'h0, 32'h0,        8'h8A}, // R8 bp0 floor 0
        '{4'd8, 3'd5, 1'b0, 2'd0, 8'h00, 32'h0, 32'h0,        8'h8A}, // R8
        '{4'd8, 3'd6, 1'b1, 2'd0, 8'h00, 32'h0, 32'h0,        8'h8A}, // R8 bp1 floor 1
        '{4'd8, 3'd5, 1'b1, 2'd0, 8'h00, 32'h0, 32'h1,        8'h8A}, // R8
        '{4'd8, 3'd6, 1'b1, 2'd0, 8'h00, 32'h5, 32'h0,        8'h8A}, // R8
        '{4'd8, 3'd5, 1'b1, 2'd0, 8'h00, 32'h0, 32'h5,        8'h8A}, // R8
        '{4'd9, 3'd7, 1'b0, 2'd0, 8'h00, 32'h1, 32'h0,        8'h8A}, // R9 common on
        '{4'd9, 3'd5, 1'b1, 2'd0, 8'h00, 32'h0, 32'h1,        8'h8A}, // R9 derived
        '{4'd9, 3'd6, 1'b1, 2'd0, 8'h00, 32'h6, 32'h0,        8'h8A}, // R9 ignored
        '{4'd9, 3'd7, 1'b0, 2'd0, 8'h00, 32'h0, 32'h0,        8'h8A}, // R9 common off
        '{4'd9, 3'd5, 1'b1, 2'd0, 8'h00, 32'h0, 32'h5,        8'h8A}, // R9 old value back
        '{4'd4, 3'd7, 1'b0, 2'd0, 8'h00, 32'h1, 32'h0,        8'h8A}, // R4
        '{4'd4, 3'd6, 1'b0, 2'd0, 8'h00, 32'h7, 32'h0,        8'h8A}, // R4 bp0 = 7
        '{4'd4, 3'd5, 1'b1, 2'd0, 8'h00, 32'h0, 32'h7,        8'h8A}, // R4 saturated
        '{4'd4, 3'd1, 1'b1, 2'd0, 8'h33, 32'h0, 32'h0,        8'h00}, // R4 mask 0x80
        '{4'd6, 3'd2, 1'b0, 2'd0, 8'h00, 32'h0, 32'h00,       8'h8A}, // R6
        '{4'd4, 3'd1, 1'b0, 2'd0, 8'hFF, 32'h0, 32'h0,        8'h00}, // R4 bp 8 masks all
        '{4'd7, 3'd3, 1'b0, 2'd0, 8'h00, 32'h0, 32'h1,        8'h00}  // R7
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // called at a falling edge; returns at the next falling edge with results visible
    task automatic do_op(input logic [2:0] c, input logic g, input logic [1:0] i,
                         input logic [7:0] p, input logic [31:0] w);
        op_valid = 1'b1; op_code = c; op_grp = g; op_idx = i; op_prio = p; op_wdata = w;
        @(negedge clk);
        op_valid = 1'b0; op_code = 3'd0;
    endtask

    task automatic do_reset(input logic [2:0] cfg);
        rst_n = 1'b0;
        cfg_prebits_m1 = cfg;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        #(8 * 200000);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        finish_run();
    end

    initial begin
        do_reset(3'd6);
        // R1 reset state
        chk("R1 rsp_valid", {31'd0, rsp_valid}, 32'd0);
        chk("R1 run_prio", {24'd0, run_prio}, 32'hFF);
        do_op(3'd5, 1'b0, 2'd0, 8'd0, 32'd0);
        chk("R1 bp0", rsp_data, 32'd2);
        do_op(3'd5, 1'b1, 2'd0, 8'd0, 32'd0);
        chk("R1 bp1", rsp_data, 32'd3);
        do_op(3'd3, 1'b1, 2'd2, 8'd0, 32'd0);
        chk("R1 bitmap", rsp_data, 32'd0);

        for (int k = 0; k < NV; k++) begin
            do_op(VEC[k].code, VEC[k].grp, VEC[k].idx, VEC[k].prio, VEC[k].wdata);
            chk($sformatf("R10 valid v%0d", k), {31'd0, rsp_valid}, 32'd1);
            chk($sformatf("R%0d rsp v%0d", VEC[k].req, k), rsp_data, VEC[k].rsp);
            chk($sformatf("R5 run v%0d", k), {24'd0, run_prio}, {24'd0, VEC[k].run});
        end

        // R10 idle cycle gives no response
        @(negedge clk);
        chk("R10 idle", {31'd0, rsp_valid}, 32'd0);

        // R2 five preemption bits: one live register, min binary point 3
        do_reset(3'd4);
        do_op(3'd4, 1'b0, 2'd1, 8'd0, 32'h0000FFFF);
        chk("R7 oob write run", {24'd0, run_prio}, 32'hFF);
        do_op(3'd3, 1'b0, 2'd1, 8'd0, 32'd0);
        chk("R7 oob read", rsp_data, 32'd0);
        do_op(3'd1, 1'b0, 2'd0, 8'hFF, 32'd0);
        chk("R2 level 31", {24'd0, run_prio}, 32'hF8);
        do_op(3'd6, 1'b0, 2'd0, 8'd0, 32'd0);
        do_op(3'd5, 1'b0, 2'd0, 8'd0, 32'd0);
        chk("R8 bp0 floor 2", rsp_data, 32'd2);
        do_op(3'd6, 1'b1, 2'd0, 8'd0, 32'd1);
        do_op(3'd5, 1'b1, 2'd0, 8'd0, 32'd0);
        chk("R8 bp1 floor 3", rsp_data, 32'd3);

        // R2 six preemption bits: two live registers, min binary point 2
        do_reset(3'd5);
        do_op(3'd4, 1'b1, 2'd2, 8'd0, 32'd1);
        do_op(3'd3, 1'b1, 2'd2, 8'd0, 32'd0);
        chk("R7 oob read six", rsp_data, 32'd0);
        chk("R7 oob run six", {24'd0, run_prio}, 32'hFF);
        do_op(3'd4, 1'b1, 2'd1, 8'd0, 32'd2);
        chk("R2 reg1 bit1", {24'd0, run_prio}, 32'h84);
        do_op(3'd2, 1'b0, 2'd0, 8'd0, 32'd0);
        chk("R6 drop six", rsp_data, 32'h84);
        chk("R6 empty after", {24'd0, run_prio}, 32'hFF);

        finish_run();
    end

endmodule